// File: doc/BRIEF.md
# Guarded Second-Order Digital Delta-Sigma Modulator

This block turns a stream of signed fixed-point samples into a one-bit stream suitable for driving a single-bit DAC. Each clock it adds the incoming sample to a chain of integrators, subtracts the full-scale value selected by the previous output bit, and takes the sign of the last integrator as the new output bit. A second-order loop is the normal mode. A first-order loop with one integrator can be selected for comparison. The sample port uses a valid/ready pair whose ready is always high. A clock without a valid sample feeds zero into the loop.

A second-order loop can lose stability when its input nears full scale. The symptom is a long stretch of identical output bits. The block measures the length of the current run of equal bits. When that length reaches a programmable limit, it applies one of two recovery actions on the same clock edge. The first action zeroes both integrators. The second action saturates each integrator to a programmable bound. Every such event sets a sticky flag and advances a saturating event counter. Software clears both through a clear strobe.

Top module: `sdm2_guarded`

## Requirements
- R1: After a synchronous active-low reset, both integrators hold zero, `bit_out` is 1, `unstable_flag` is 0, `unstable_count` is 0, and `in_ready` is 1.
- R2: The output bit is 1 when the active comparator source is greater than or equal to zero. The feedback value is +2^(IN_W-1) for a 1 and -2^(IN_W-1) for a 0. In first-order mode (`cfg_order2`=0), the comparator source is integrator 1, and each clock integrator 1 gains the sample minus the feedback.
- R3: In second-order mode (`cfg_order2`=1), the comparator source is integrator 2. Integrator 1 gains the sample minus the feedback. Integrator 2 gains the new, undelayed integrator-1 sum minus the feedback.
- R4: A clock with `in_valid` low contributes a sample of zero, whatever value `in_sample` carries.
- R5: The run length counts the clocks, including the current one, over which `bit_out` has kept its present value since the last toggle or the last recovery. A recovery fires in a clock where all three hold: second-order mode is on, `cfg_run_limit` is nonzero, and the run length is at least `cfg_run_limit`. The run count restarts after each recovery. A limit of 0 disables the guard.
- R6: With `cfg_recover_clip`=0, a recovery loads zero into both integrators at the edge that ends the firing clock.
- R7: With `cfg_recover_clip`=1, a recovery loads each integrator's freshly computed sum, saturated to the range [-`cfg_clip_bound`, +`cfg_clip_bound`].
- R8: In first-order mode no recovery ever fires. Integrator 2 is held at zero.
- R9: Each recovery sets `unstable_flag` and increments `unstable_count`. The counter saturates at its all-ones value.
- R10: `evt_clear` zeroes `unstable_flag` and `unstable_count` at the next edge. If a recovery fires in the same clock, the flag ends at 1 and the count ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample qualifier; when low the loop sees zero |
| in_sample | input | IN_W | Signed input sample |
| in_ready | output | 1 | Always 1; a sample is taken every clock |
| cfg_order2 | input | 1 | 1 selects the second-order loop, 0 selects first order |
| cfg_recover_clip | input | 1 | 0 selects zeroing recovery, 1 selects saturation recovery |
| cfg_run_limit | input | CNT_W | Run length that fires a recovery; 0 disables |
| cfg_clip_bound | input | IN_W+GUARD_BITS-1 | Magnitude bound used by saturation recovery |
| evt_clear | input | 1 | Clears the event flag and the event counter |
| bit_out | output | 1 | Modulator output bit |
| unstable_flag | output | 1 | Sticky flag, set by any recovery |
| unstable_count | output | EVT_W | Saturating count of recoveries |

## Verification
A recovery and a software clear can fall in the same clock, and the bench provokes this on purpose. It runs a near-full-scale input under a short run limit and uses its reference model to predict the clock in which a recovery will fire. It then raises `evt_clear` in exactly that clock. The test passes when the flag reads 1 and the count reads 1 afterwards, not 0. The recovery action also coincides with the normal integrator update. The bench judges this by comparing `bit_out` every clock against a model that applies the zeroing or the saturation to the freshly computed sums.

// File: rtl/sdm2_guarded_pkg.sv
// Package: shared types and helpers for the guarded delta-sigma modulator.
// Assumes callers pass a non-negative bound.
package sdm2_guarded_pkg;

    // Recovery action applied when a long run is detected.
    typedef enum logic {
        REC_ZERO = 1'b0,
        REC_CLIP = 1'b1
    } recover_e;

    // Saturate a signed value to [-bound, +bound].
    function automatic logic signed [63:0] sat_sym(input logic signed [63:0] v,
                                                   input logic signed [63:0] bound);
        logic signed [63:0] r;
        r = v;
        if (v > bound)       r = bound;
        else if (v < -bound) r = -bound;
        return r;
    endfunction

endpackage

// File: rtl/sdm2_integrator.sv
// Module: one integrator register of the loop.
// It takes an already formed raw next value (sum) and applies the recovery
// action chosen for this clock, or holds zero when the stage is unused.
// Assumes bound is non-negative and narrower than ACC_W.
module sdm2_integrator
    import sdm2_guarded_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold_zero,
    input  logic                    recover,
    input  recover_e                rec_mode,
    input  logic [ACC_W-2:0]        bound,
    input  logic signed [ACC_W-1:0] raw_next,
    output logic signed [ACC_W-1:0] acc_q
);

    logic signed [ACC_W-1:0] bnd;
    logic signed [ACC_W-1:0] acc_d;

    // Select the value loaded at the next edge.
    always_comb begin
        bnd   = $signed({1'b0, bound});
        acc_d = raw_next;
        if (recover) begin
            if (rec_mode == REC_CLIP)
                acc_d = ACC_W'(sat_sym(64'(raw_next), 64'(bnd)));
            else
                acc_d = '0;
        end
    end

    // State register with synchronous reset and forced-zero hold.
    always_ff @(posedge clk) begin
        if (!rst_n)         acc_q <= '0;
        else if (hold_zero) acc_q <= '0;
        else                acc_q <= acc_d;
    end

    AST_ZERO_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && rec_mode == REC_ZERO) |=> (acc_q == '0)); // R6
    AST_CLIP_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && rec_mode == REC_CLIP && !hold_zero) |=>
            (acc_q <= $past(bnd) && acc_q >= -$past(bnd))); // R7
    AST_UNUSED_STAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> (acc_q == '0)); // R8

endmodule

// File: rtl/sdm2_run_guard.sv
// Module: run-length watchdog on the output bitstream plus event bookkeeping.
// It measures how long bit_in has held its value. It fires trigger when the
// run reaches the limit (only while enable is high, and never with a zero limit).
// It keeps a sticky flag and a saturating event counter that software clears.
// Assumes bit_in is a registered-state signal that is stable for the whole clock.
module sdm2_run_guard #(
    parameter int CNT_W = 8,
    parameter int EVT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             bit_in,
    input  logic [CNT_W-1:0] limit,
    input  logic             evt_clear,
    output logic             trigger,
    output logic             sticky,
    output logic [EVT_W-1:0] count
);

    localparam logic [CNT_W-1:0] RUN_MAX = '1;
    localparam logic [EVT_W-1:0] EVT_MAX = '1;

    logic [CNT_W-1:0] run_q;
    logic             last_q;
    logic [CNT_W-1:0] cur_len;

    // Length of the run that includes the current clock.
    always_comb begin
        if (run_q != '0 && bit_in == last_q)
            cur_len = (run_q == RUN_MAX) ? RUN_MAX : run_q + 1'b1;
        else
            cur_len = CNT_W'(1);
        trigger = enable && (limit != '0) && (cur_len >= limit);
    end

    // Run bookkeeping; a recovery restarts the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else begin
            run_q  <= trigger ? '0 : cur_len;
            last_q <= bit_in;
        end
    end

    // Sticky flag and event counter; a recovery in the clearing clock survives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky <= 1'b0;
            count  <= '0;
        end else if (evt_clear) begin
            sticky <= trigger;
            count  <= trigger ? EVT_W'(1) : '0;
        end else if (trigger) begin
            sticky <= 1'b1;
            if (count != EVT_MAX) count <= count + 1'b1;
        end
    end

    AST_FLAG_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> sticky); // R9
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && !evt_clear && count != EVT_MAX) |=> (count == $past(count) + 1'b1)); // R9
    AST_CLEAR_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clear && !trigger) |=> (!sticky && count == '0)); // R10
    AST_CLEAR_WITH_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_clear && trigger) |=> (sticky && count == EVT_W'(1))); // R10
    AST_GUARD_OFF_FIRST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(sticky) || $past(evt_clear)); // R8

endmodule

// File: rtl/sdm2_guarded.sv
// Module: top of the guarded delta-sigma modulator.
// It forms the summing nodes, drives the integrator chain (the first stage
// undelayed into the second), takes the comparator and feedback, and hands
// the bitstream to the run guard. It assumes the configuration stays static
// while a stream runs.
module sdm2_guarded
    import sdm2_guarded_pkg::*;
#(
    parameter int IN_W      = 12,
    parameter int GUARD_BITS = 4,
    parameter int CNT_W     = 8,
    parameter int EVT_W     = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic signed [IN_W-1:0]         in_sample,
    output logic                           in_ready,
    input  logic                           cfg_order2,
    input  logic                           cfg_recover_clip,
    input  logic [CNT_W-1:0]               cfg_run_limit,
    input  logic [IN_W+GUARD_BITS-2:0]     cfg_clip_bound,
    input  logic                           evt_clear,
    output logic                           bit_out,
    output logic                           unstable_flag,
    output logic [EVT_W-1:0]               unstable_count
);

    localparam int ACC_W   = IN_W + GUARD_BITS;
    localparam int N_STAGE = 2;
    localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(1) << (IN_W - 1);
    localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] fb;
    logic signed [ACC_W-1:0] acc   [N_STAGE];
    logic signed [ACC_W-1:0] raw   [N_STAGE];
    logic signed [ACC_W-1:0] cmp_src;
    logic                    recover;
    recover_e                rec_mode;

    assign in_ready = 1'b1;
    assign rec_mode = recover_e'(cfg_recover_clip);

    // Input qualification and 1-bit DAC feedback.
    always_comb begin
        x_ext = in_valid ? {{GUARD_BITS{in_sample[IN_W-1]}}, in_sample} : '0;
        fb    = bit_out ? FS_POS : FS_NEG;
    end

    // Summing nodes: stage 1 takes the sample, stage 2 takes stage 1's undelayed sum.
    always_comb begin
        raw[0] = acc[0] + x_ext - fb;
        raw[1] = acc[1] + raw[0] - fb;
    end

    // Comparator on the last active stage.
    always_comb begin
        cmp_src = cfg_order2 ? acc[1] : acc[0];
        bit_out = ~cmp_src[ACC_W-1];
    end

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        sdm2_integrator #(.ACC_W(ACC_W)) u_int (
            .clk      (clk),
            .rst_n    (rst_n),
            .hold_zero((g == 0) ? 1'b0 : ~cfg_order2),
            .recover  (recover),
            .rec_mode (rec_mode),
            .bound    (cfg_clip_bound),
            .raw_next (raw[g]),
            .acc_q    (acc[g])
        );
    end

    sdm2_run_guard #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (cfg_order2),
        .bit_in   (bit_out),
        .limit    (cfg_run_limit),
        .evt_clear(evt_clear),
        .trigger  (recover),
        .sticky   (unstable_flag),
        .count    (unstable_count)
    );

    AST_ZERO_GIVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (recover && rec_mode == REC_ZERO) |=> bit_out); // R6
    AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready); // R1

endmodule

// File: tb/sdm2_guarded_tb.sv
`timescale 1ns/1ps
module sdm2_guarded_tb;

    localparam int IN_W  = 12;
    localparam int GB    = 4;
    localparam int ACC_W = IN_W + GB;
    localparam int CNT_W = 8;
    localparam int EVT_W = 8;
    localparam logic signed [ACC_W-1:0] FS = 2048;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0;
    logic signed [IN_W-1:0] in_sample = '0;
    logic in_ready;
    logic cfg_order2 = 0;
    logic cfg_recover_clip = 0;
    logic [CNT_W-1:0] cfg_run_limit = '0;
    logic [ACC_W-2:0] cfg_clip_bound = '0;
    logic evt_clear = 0;
    logic bit_out;
    logic unstable_flag;
    logic [EVT_W-1:0] unstable_count;

    int n_checks = 0;
    int n_fail = 0;
    int ones = 0;

    // Reference model state
    logic signed [ACC_W-1:0] m_i1, m_i2;
    logic [CNT_W-1:0] m_run;
    logic m_last, m_flag;
    logic [EVT_W-1:0] m_cnt;

    always #4 clk = ~clk;

    sdm2_guarded #(.IN_W(IN_W), .GUARD_BITS(GB), .CNT_W(CNT_W), .EVT_W(EVT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .cfg_order2(cfg_order2), .cfg_recover_clip(cfg_recover_clip),
        .cfg_run_limit(cfg_run_limit), .cfg_clip_bound(cfg_clip_bound),
        .evt_clear(evt_clear), .bit_out(bit_out), .unstable_flag(unstable_flag),
        .unstable_count(unstable_count)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic m_bit();
        return cfg_order2 ? !m_i2[ACC_W-1] : !m_i1[ACC_W-1];
    endfunction

    function automatic logic [CNT_W-1:0] m_len();
        logic b;
        b = m_bit();
        if (m_run != '0 && b == m_last) return (m_run == '1) ? m_run : m_run + 1'b1;
        return CNT_W'(1);
    endfunction

    function automatic logic m_trig();
        return cfg_order2 && cfg_run_limit != '0 && m_len() >= cfg_run_limit;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0; evt_clear = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_i1 = '0; m_i2 = '0; m_run = '0; m_last = 0; m_flag = 0; m_cnt = '0;
    endtask

    // One clock: drive, advance model, compare at the next falling edge.
    task automatic step(input logic signed [IN_W-1:0] x, input logic v,
                        input logic clr, input string tag);
        logic signed [ACC_W-1:0] xe, fb, s1, s2, bnd;
        logic b, t;
        logic [CNT_W-1:0] len;
        in_sample = x; in_valid = v; evt_clear = clr;
        b   = m_bit();
        len = m_len();
        t   = m_trig();
        xe  = v ? {{GB{x[IN_W-1]}}, x} : '0;
        fb  = b ? FS : -FS;
        s1  = m_i1 + xe - fb;
        s2  = m_i2 + s1 - fb;
        bnd = $signed({1'b0, cfg_clip_bound});
        if (t) begin
            if (cfg_recover_clip) begin
                if (s1 > bnd) s1 = bnd; else if (s1 < -bnd) s1 = -bnd;
                if (s2 > bnd) s2 = bnd; else if (s2 < -bnd) s2 = -bnd;
            end else begin
                s1 = '0; s2 = '0;
            end
        end
        @(posedge clk);
        m_i1 = s1;
        m_i2 = cfg_order2 ? s2 : '0;
        m_run = t ? '0 : len;
        m_last = b;
        if (clr) begin
            m_flag = t; m_cnt = t ? EVT_W'(1) : '0;
        end else if (t) begin
            m_flag = 1; if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
        end
        @(negedge clk);
        evt_clear = 0;
        if (bit_out) ones++;
        check(bit_out == m_bit() && unstable_flag == m_flag && unstable_count == m_cnt,
              tag, {bit_out, unstable_flag, 8'(unstable_count)},
              {m_bit(), m_flag, 8'(m_cnt)});
    endtask

    task automatic t_reset();
        do_reset();
        check(bit_out == 1, "R1 bit_out", bit_out, 1);
        check(!unstable_flag && unstable_count == 0, "R1 status", unstable_count, 0);
        check(in_ready == 1, "R1 in_ready", in_ready, 1);
    endtask

    task automatic t_first_order();
        cfg_order2 = 0; cfg_run_limit = 8;
        do_reset();
        ones = 0;
        for (int i = 0; i < 512; i++) step(12'sd1024, 1, 0, "R2 first order dc");
        check(ones >= 381 && ones <= 387, "R2 density 0.75", ones, 384);
        for (int i = 0; i < 300; i++) step(IN_W'((i * 37) % 3000 - 1500), 1, 0, "R2 first order ramp");
        for (int i = 0; i < 300; i++) step(12'sd2047, 1, 0, "R8 first order no guard");
        check(!unstable_flag, "R8 flag stays low", unstable_flag, 0);
    endtask

    task automatic t_second_order();
        cfg_order2 = 1; cfg_run_limit = 0;
        do_reset();
        ones = 0;
        for (int i = 0; i < 512; i++) step(-12'sd512, 1, 0, "R3 second order dc");
        check(ones >= 188 && ones <= 196, "R3 density 0.375", ones, 192);
        for (int i = 0; i < 600; i++) begin
            int p;
            p = i % 60;
            step(IN_W'((p < 30) ? (p * 40 - 600) : (1800 - p * 40)), 1, 0, "R3 triangle");
        end
        check(!unstable_flag, "R5 zero limit disables", unstable_flag, 0);
    endtask

    task automatic t_invalid();
        cfg_order2 = 1; cfg_run_limit = 0;
        do_reset();
        ones = 0;
        for (int i = 0; i < 256; i++) step(12'sd1900, 0, 0, "R4 invalid is zero");
        check(ones >= 126 && ones <= 130, "R4 density 0.5", ones, 128);
    endtask

    task automatic t_zero_recovery();
        cfg_order2 = 1; cfg_run_limit = 6; cfg_recover_clip = 0;
        do_reset();
        for (int i = 0; i < 400; i++) step(12'sd2047, 1, 0, "R6 zero recovery");
        check(unstable_flag == 1, "R5 long run flagged", unstable_flag, 1);
    endtask

    task automatic t_clip_recovery();
        cfg_order2 = 1; cfg_run_limit = 6; cfg_recover_clip = 1; cfg_clip_bound = 300;
        do_reset();
        for (int i = 0; i < 400; i++) step(-12'sd2047, 1, 0, "R7 clip recovery");
        check(unstable_flag == 1, "R7 event seen", unstable_flag, 1);
    endtask

    task automatic t_collide();
        logic hit;
        cfg_order2 = 1; cfg_run_limit = 4; cfg_recover_clip = 0;
        do_reset();
        for (int i = 0; i < 200; i++) step(12'sd2047, 1, 0, "R9 events accrue");
        step(12'sd2047, 1, 1, "R10 plain clear");
        hit = 0;
        for (int i = 0; i < 2000 && !hit; i++) begin
            if (m_trig()) begin
                step(12'sd2047, 1, 1, "R10 clear with event");
                hit = 1;
            end else step(12'sd2047, 1, 0, "R10 wait for event");
        end
        check(hit && unstable_flag && unstable_count == 1, "R10 event survives clear",
              unstable_count, 1);
    endtask

    task automatic t_saturate();
        cfg_order2 = 1; cfg_run_limit = 2; cfg_recover_clip = 0;
        do_reset();
        for (int i = 0; i < 1500; i++) step(12'sd2047, 1, 0, "R9 count saturation");
        check(unstable_count == 8'hFF, "R9 count saturates", unstable_count, 255);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_first_order();
        t_second_order();
        t_invalid();
        t_zero_recovery();
        t_clip_recovery();
        t_collide();
        t_saturate();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule